// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block is a register-mapped general-purpose I/O controller serving 96 pins arranged as three banks of 32. Each pin has a direction bit and an output latch. Software can load the latch as a whole word, or change single bits without a read-modify-write by writing ones to a set word or a clear word. On the input side every pin passes through a two-stage synchronizer and an optional inversion. It can then raise a pending bit on a rising edge, a falling edge, a high level or a low level, and each of these four senses has its own enable mask.

Pending bits are held per bank until software writes ones to clear them. A level condition that still holds sets its bit again straight away. All pending bits of all banks drive one shared interrupt line. A second per-bank word records which pending events came from edges, so a handler can tell edge events from level events. Access is through a single-cycle 32-bit read/write port. Read data is registered and appears one cycle after the request.

Top module: `gpio_bk_top`

## Requirements
- R1: The address bits [7:4] select a register group and bits [3:2] select a bank slot. Pin N is bit N mod 32 of bank N/32. Group codes: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rising enable, 6 falling enable, 7 high-level enable, 8 low-level enable, 9 pending status, 10 edge record.
- R2: A direction bit of 1 drives the pin's gpio_oe_o bit high (output). A 0 makes the pin an input.
- R3: A write to the data group loads the output latch. A 1 written to the set group drives that latch bit to 1, and a 1 written to the clear group drives it to 0. Zero bits in set or clear writes leave the latch unchanged. gpio_o shows the latch.
- R4: A read of the data group returns the latch for output pins and the synchronized input for input pins. The input goes through two flops before use.
- R5: A pin with none of its four sense enables set never raises a pending bit.
- R6: A rising enable flags a 0-to-1 change of the conditioned input, and a falling enable flags a 1-to-0 change. With both enabled, either edge is flagged.
- R7: A high-level or low-level enable flags the pin on every cycle in which the conditioned input has that level. A cleared level bit sets again while the condition holds.
- R8: Writing ones to the status group clears only those pending bits. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: irq_o is high when any pending bit in any bank is set.
- R10: A polarity bit of 1 inverts the pin's input before edge detection, level detection and data readback.
- R11: The edge-record group sets a bit when an enabled edge event latches for that pin. Level events do not set it. Writing ones to the group clears the written bits.
- R12: Accesses to bank slot 3 write nothing and read 0. Reads of the set and clear groups return 0.
- R13: After reset all registers, outputs and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| gpio_i | input | 96 | Pin inputs |
| gpio_o | output | 96 | Output latch values |
| gpio_oe_o | output | 96 | Output enables |
| irq_o | output | 1 | Shared interrupt |

## Verification
Some checks run on every cycle, all on bank 0 and the output side. Set and clear writes must change exactly the written latch bits. A direction write must appear on the output enables one cycle later. A write to the unused bank slot must leave every output enable unchanged. The interrupt line must never rise unless some sense enable is set. The input side needs the bench's scenarios: the edge polarities, level re-arming after a clear, set-over-clear priority, selective clearing, polarity inversion and the edge record all depend on sequences of pin changes and register writes.

// File: rtl/gpio_bk_pkg.sv
package gpio_bk_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned GRP_W  = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_DIR  = 4'd0,
    GRP_POL  = 4'd1,
    GRP_DATA = 4'd2,
    GRP_SET  = 4'd3,
    GRP_CLR  = 4'd4,
    GRP_RISE = 4'd5,
    GRP_FALL = 4'd6,
    GRP_HIGH = 4'd7,
    GRP_LOW  = 4'd8,
    GRP_STAT = 4'd9,
    GRP_EDGE = 4'd10
  } grp_e;
endpackage

// File: rtl/gpio_bk_sync.sv
module gpio_bk_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bk_bank.sv
module gpio_bk_bank
  import gpio_bk_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  grp_e         grp_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] rd_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic         pend_o,
  output logic         en_any_o
);
  logic [W-1:0] dir_q, pol_q, out_q;
  logic [W-1:0] ren_q, fen_q, hen_q, len_q;
  logic [W-1:0] stat_q, edge_q, prev_q;
  logic [W-1:0] lvl, rise, fall, edge_evt, evt;
  logic [W-1:0] stat_clr, edge_clr;

  // conditioned input
  assign lvl      = pin_sync_i ^ pol_q;
  assign rise     = lvl & ~prev_q;
  assign fall     = ~lvl & prev_q;
  assign edge_evt = (rise & ren_q) | (fall & fen_q);
  assign evt      = edge_evt | (lvl & hen_q) | (~lvl & len_q);

  assign stat_clr = (wr_i && grp_i == GRP_STAT) ? wdata_i : '0;
  assign edge_clr = (wr_i && grp_i == GRP_EDGE) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      pol_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      hen_q <= '0;
      len_q <= '0;
    end else if (wr_i) begin
      unique case (grp_i)
        GRP_DIR:  dir_q <= wdata_i;
        GRP_POL:  pol_q <= wdata_i;
        GRP_DATA: out_q <= wdata_i;
        GRP_SET:  out_q <= out_q | wdata_i;
        GRP_CLR:  out_q <= out_q & ~wdata_i;
        GRP_RISE: ren_q <= wdata_i;
        GRP_FALL: fen_q <= wdata_i;
        GRP_HIGH: hen_q <= wdata_i;
        GRP_LOW:  len_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      edge_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | evt;
      edge_q <= (edge_q & ~edge_clr) | edge_evt;
      prev_q <= lvl;
    end
  end

  always_comb begin
    unique case (grp_i)
      GRP_DIR:  rd_o = dir_q;
      GRP_POL:  rd_o = pol_q;
      GRP_DATA: rd_o = (dir_q & out_q) | (~dir_q & lvl);
      GRP_RISE: rd_o = ren_q;
      GRP_FALL: rd_o = fen_q;
      GRP_HIGH: rd_o = hen_q;
      GRP_LOW:  rd_o = len_q;
      GRP_STAT: rd_o = stat_q;
      GRP_EDGE: rd_o = edge_q;
      default:  rd_o = '0;
    endcase
  end

  assign out_o    = out_q;
  assign oe_o     = dir_q;
  assign pend_o   = |stat_q;
  assign en_any_o = |(ren_q | fen_q | hen_q | len_q);
endmodule

// File: rtl/gpio_bk_top.sv
module gpio_bk_top
  import gpio_bk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [WORD_W-1:0]             rdata_o,
  input  logic [NUM_BANKS*WORD_W-1:0]   gpio_i,
  output logic [NUM_BANKS*WORD_W-1:0]   gpio_o,
  output logic [NUM_BANKS*WORD_W-1:0]   gpio_oe_o,
  output logic                          irq_o
);
  localparam int unsigned NPINS  = NUM_BANKS * WORD_W;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned SLOT_L = 2;
  localparam int unsigned GRP_L  = SLOT_L + SLOT_W;

  logic [NPINS-1:0]  pin_sync;
  logic [SLOT_W-1:0] slot;
  grp_e              grp;
  logic [WORD_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend, bank_en;
  logic [WORD_W-1:0] rd_sel, rdata_q;
  logic              any_en_w;

  assign slot = addr_i[GRP_L-1:SLOT_L];
  assign grp  = grp_e'(addr_i[GRP_L+GRP_W-1:GRP_L]);

  gpio_bk_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_b;
    assign wr_b = req_i && we_i && (slot == SLOT_W'(b));
    gpio_bk_bank #(.W(WORD_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_b),
      .grp_i     (grp),
      .wdata_i   (wdata_i),
      .pin_sync_i(pin_sync[b*WORD_W +: WORD_W]),
      .rd_o      (bank_rd[b]),
      .out_o     (gpio_o[b*WORD_W +: WORD_W]),
      .oe_o      (gpio_oe_o[b*WORD_W +: WORD_W]),
      .pend_o    (bank_pend[b]),
      .en_any_o  (bank_en[b])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (slot == SLOT_W'(b)) rd_sel = bank_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_sel;
  end

  assign rdata_o  = rdata_q;
  assign irq_o    = |bank_pend;
  assign any_en_w = |bank_en;
endmodule

// File: rtl/gpio_bk_chk.sv
module gpio_bk_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] out0_i,
  input logic [31:0] oe0_i,
  input logic [95:0] oe_all_i,
  input logic        irq_i,
  input logic        any_en_i
);
  AST_SET_DRIVES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h30) |=> ((out0_i & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_SET_KEEPS_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h30) |=> ((out0_i & ~$past(wdata_i)) == ($past(out0_i) & ~$past(wdata_i)))); // R3
  AST_CLR_DRIVES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h40) |=> ((out0_i & $past(wdata_i)) == 32'h0)); // R3
  AST_CLR_KEEPS_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h40) |=> ((out0_i & ~$past(wdata_i)) == ($past(out0_i) & ~$past(wdata_i)))); // R3
  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h00) |=> (oe0_i == $past(wdata_i))); // R2
  AST_UNUSED_SLOT_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h0C) |=> $stable(oe_all_i)); // R12
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(any_en_i)); // R5
endmodule

bind gpio_bk_top gpio_bk_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .out0_i  (gpio_o[31:0]),
  .oe0_i   (gpio_oe_o[31:0]),
  .oe_all_i(gpio_oe_o),
  .irq_i   (irq_o),
  .any_en_i(any_en_w)
);

// File: tb/tb_gpio_bk_top.sv
module tb_gpio_bk_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [95:0] gpio_in = '0, gpio_out, gpio_oe;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_v = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gpio_bk_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(gpio_in), .gpio_o(gpio_out),
    .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the queue
  always @(posedge clk) mon_v <= req && !we;
  always @(negedge clk) begin
    if (mon_v && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {64'h0, rdata}, {64'h0, e});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pins(int idx, logic v);
    @(negedge clk); gpio_in[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 irq", {95'h0, irq}, 96'h0);
    chk("R13 oe", gpio_oe, 96'h0);
    chk("R13 out", gpio_out, 96'h0);
    rd(8'h00, 32'h0, "R13 dir");
    rd(8'h90, 32'h0, "R13 stat");
    // R2 direction
    wr(8'h00, 32'hFF);
    chk("R2 oe", gpio_oe, 96'hFF);
    rd(8'h00, 32'hFF, "R2 dir readback");
    // R3 latch writes
    wr(8'h20, 32'h0F);
    chk("R3 data write", {64'h0, gpio_out[31:0]}, 96'h0F);
    wr(8'h30, 32'hF0);
    chk("R3 set", {64'h0, gpio_out[31:0]}, 96'hFF);
    wr(8'h40, 32'h03);
    chk("R3 clear", {64'h0, gpio_out[31:0]}, 96'hFC);
    rd(8'h20, 32'hFC, "R4 data mix");
    // R4 input readback, R5 no enable
    pins(8, 1'b1);
    rd(8'h20, 32'h1FC, "R4 input pin");
    rd(8'h90, 32'h0, "R5 no pending");
    chk("R5 irq", {95'h0, irq}, 96'h0);
    // R6 rising only
    wr(8'h50, 32'h200);
    pins(9, 1'b1);
    rd(8'h90, 32'h200, "R6 rising");
    chk("R9 irq bank0", {95'h0, irq}, 96'h1);
    rd(8'hA0, 32'h200, "R11 edge record");
    wr(8'h90, 32'h200);
    rd(8'h90, 32'h0, "R8 clear");
    chk("R9 irq low", {95'h0, irq}, 96'h0);
    pins(9, 1'b0);
    rd(8'h90, 32'h0, "R6 no falling");
    wr(8'hA0, 32'h200);
    rd(8'hA0, 32'h0, "R11 edge clear");
    // R6 both edges on pin 10
    wr(8'h60, 32'h400);
    wr(8'h50, 32'h600);
    pins(10, 1'b1);
    rd(8'h90, 32'h400, "R6 both rise");
    wr(8'h90, 32'h400);
    pins(10, 1'b0);
    rd(8'h90, 32'h400, "R6 both fall");
    // R8 selective clear
    pins(9, 1'b1);
    rd(8'h90, 32'h600, "R8 two pending");
    wr(8'h90, 32'h200);
    rd(8'h90, 32'h400, "R8 selective");
    wr(8'h90, 32'h400);
    rd(8'h90, 32'h0, "R8 all cleared");
    // R7 high level, bank 2 pin 70 (R1 mapping)
    pins(70, 1'b1);
    wr(8'h78, 32'h40);
    rd(8'h98, 32'h40, "R7 R1 high level");
    chk("R9 irq bank2", {95'h0, irq}, 96'h1);
    wr(8'h98, 32'h40);
    rd(8'h98, 32'h40, "R7 R8 rearm");
    rd(8'hA8, 32'h0, "R11 level not edge");
    pins(70, 1'b0);
    wr(8'h98, 32'h40);
    rd(8'h98, 32'h0, "R7 level gone");
    chk("R9 irq idle", {95'h0, irq}, 96'h0);
    // R7 low level bank 1, R10 polarity
    wr(8'h84, 32'h1);
    rd(8'h94, 32'h1, "R7 low level");
    wr(8'h14, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h94, 32'h1);
    rd(8'h94, 32'h0, "R10 inverted level");
    rd(8'h24, 32'h1, "R10 inverted data");
    chk("R10 irq", {95'h0, irq}, 96'h0);
    // R12 unused slot and write-only groups
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R12 slot3 read");
    chk("R12 oe unchanged", gpio_oe, 96'hFF);
    rd(8'h30, 32'h0, "R12 set reads zero");
    // R1 top pin of bank 2
    pins(95, 1'b1);
    rd(8'h28, 32'h8000_0000, "R1 pin95");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule